// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block holds the two serial engines of an asynchronous serial port. The transmitter takes a byte from a transmit queue, frames it as a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits, and shifts it onto the line. The receiver watches the incoming line, qualifies start bits, samples each bit in the middle of its cell and hands a byte to a receive queue with parity, framing and break flags.

Both engines step on a single-cycle enable, `tick`, that runs at 16 times the bit rate, so one bit cell lasts 16 ticks. The frame format comes from a seven-bit slice of the port's control word, kept at its word bit positions 21 down to 15. Each engine latches that slice when a frame begins, so a change in the middle of a frame takes effect only on the next frame. The queues, the register decode and the line handshake outputs sit outside the block. Only the clear-to-send input is used, and only when handshake mode is selected.

Top module: `serial_framer_top`

## Requirements
- R1: After synchronous reset, `txd` is 1, `tx_busy` is 0, `txq_pop` is 0 while the queue is empty, and `rxq_push` is 0.
- R2: `ctrl_fmt[21:20]` sets the data length as 0→8, 1→7, 2→6 and 3→5 bits. The transmitter sends only that many bits. On the receiver, bits of `rxq_data` above the length are 0.
- R3: Data bits go out least significant bit first. Every bit cell, start bit included, lasts 16 ticks.
- R4: `ctrl_fmt[19]` set adds a parity bit after the data bits. With `ctrl_fmt[18]` = 0 the parity is even (data plus parity has an even number of ones). With `ctrl_fmt[18]` = 1 it is odd.
- R5: `ctrl_fmt[17:16]` = 1 gives two stop bits. Any other value gives one. `tx_busy` stays 1 until the last stop bit ends.
- R6: `txq_pop` is a single-cycle pulse, raised only while the transmitter is not busy and `txq_empty` is 0. The start bit appears on `txd` from the clock edge that consumes the pop, and `tx_busy` is 1 from that edge.
- R7: With `ctrl_fmt[15]` = 0 (handshake mode), no frame starts while `cts_n` is 1. With `ctrl_fmt[15]` = 1 (two-wire mode), `cts_n` is ignored.
- R8: `tx_idle` is 1 exactly when `txq_empty` is 1 and `tx_busy` is 0.
- R9: The receiver checks a start bit at its mid-cell, 8 ticks after the first low sample. A low pulse that has ended by then gives no byte.
- R10: `rx_parity_err` is 1 with a pushed byte when parity is enabled and the received parity bit does not match the selected sense.
- R11: `rx_frame_err` is 1 with a pushed byte when the first stop bit samples low. The receiver then waits for the line to go high before looking for a new start bit.
- R12: A line held low for a whole frame gives one byte 0x00 with `rx_frame_err` and `rx_break` both 1. No further byte follows while the line stays low.
- R13: `rxq_push` is a one-cycle pulse issued at mid-cell of the first stop bit. The three error flags are 0 in every cycle without a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle enable at 16x the bit rate |
| ctrl_fmt | input | 7 | Control word bits 21:15: length, parity enable, parity sense, stop bits, two-wire select |
| txq_empty | input | 1 | Transmit queue has no entry |
| txq_data | input | 8 | Head entry of the transmit queue |
| cts_n | input | 1 | Clear to send, active low, used in handshake mode |
| txq_pop | output | 1 | Takes the head entry of the transmit queue this cycle |
| txd | output | 1 | Serial transmit line, idle high |
| tx_busy | output | 1 | Transmitter is shifting a frame |
| tx_idle | output | 1 | Queue empty and shifter idle |
| rxd | input | 1 | Serial receive line, asynchronous |
| rxq_push | output | 1 | Writes a received byte to the receive queue |
| rxq_data | output | 8 | Received byte, right aligned |
| rx_parity_err | output | 1 | Parity mismatch, valid with the push |
| rx_frame_err | output | 1 | First stop bit low, valid with the push |
| rx_break | output | 1 | Whole frame low, valid with the push |

## Verification
The transmitter starts its start bit on the edge that consumes `txq_pop`. The first cell can be up to three clocks short, depending on tick phase, and every later cell is exactly 64 clocks with the bench tick every fourth clock. The bench therefore samples `txd` 32 clocks after the pop and then every 64 clocks, near each cell's centre. On the receive side, the push lands two synchroniser clocks plus about half a cell into the first stop bit. The bench drives each cell for 64 clocks and reads its push record at the end of the stop cell, so the result is due well inside the window that it checks.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int MAX_BITS = 8;
    localparam int LEN_W    = 2;

    typedef enum logic [LEN_W-1:0] {
        LEN_8 = 2'd0,
        LEN_7 = 2'd1,
        LEN_6 = 2'd2,
        LEN_5 = 2'd3
    } len_code_e;

    typedef struct packed {
        len_code_e len;
        logic      par_en;
        logic      par_odd;
        logic      two_stop;
        logic      two_wire;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_PAR,
        SER_STOP,
        SER_HOLD
    } ser_state_e;

    function automatic frame_cfg_t unpack_cfg(input logic [21:15] f);
        frame_cfg_t c;
        c.len      = len_code_e'(f[21:20]);
        c.par_en   = f[19];
        c.par_odd  = f[18];
        c.two_stop = (f[17:16] == 2'b01);
        c.two_wire = f[15];
        return c;
    endfunction

    function automatic logic [3:0] data_bits(input len_code_e l);
        return 4'(MAX_BITS) - {2'b00, l};
    endfunction

    function automatic logic [MAX_BITS-1:0] len_mask(input len_code_e l);
        return {MAX_BITS{1'b1}} >> l;
    endfunction

    function automatic logic par_bit(input logic [MAX_BITS-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/framer_sync.sv
module framer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/framer_tx.sv
module framer_tx
    import framer_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic                txq_empty,
    input  logic [MAX_BITS-1:0] txq_data,
    input  logic                cts_n,
    output logic                txq_pop,
    output logic                txd,
    output logic                busy
);
    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;

    ser_state_e          state;
    frame_cfg_t          cfg_q;
    logic [MAX_BITS-1:0] shreg;
    logic                par_q;
    logic [3:0]          bitcnt;
    logic [CW-1:0]       tcnt;
    logic                cell_end;
    logic [3:0]          nbits;
    logic [MAX_BITS-1:0] masked;

    assign masked   = txq_data & len_mask(cfg.len);
    assign nbits    = data_bits(cfg_q.len);
    assign cell_end = tick && (tcnt == CW'(OSR - 1));
    assign txq_pop  = (state == SER_IDLE) && !txq_empty && (cfg.two_wire || !cts_n);
    assign busy     = (state != SER_IDLE);

    always_comb begin
        case (state)
            SER_START: txd = 1'b0;
            SER_DATA:  txd = shreg[0];
            SER_PAR:   txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SER_IDLE;
            cfg_q  <= '0;
            shreg  <= '0;
            par_q  <= 1'b0;
            bitcnt <= '0;
            tcnt   <= '0;
        end else begin
            if (state != SER_IDLE && tick)
                tcnt <= cell_end ? '0 : tcnt + 1'b1;
            case (state)
                SER_IDLE: begin
                    if (txq_pop) begin
                        cfg_q  <= cfg;
                        shreg  <= masked;
                        par_q  <= par_bit(masked, cfg.par_odd);
                        tcnt   <= '0;
                        bitcnt <= '0;
                        state  <= SER_START;
                    end
                end
                SER_START: begin
                    if (cell_end) begin
                        bitcnt <= '0;
                        state  <= SER_DATA;
                    end
                end
                SER_DATA: begin
                    if (cell_end) begin
                        shreg <= shreg >> 1;
                        if (bitcnt == nbits - 4'd1) begin
                            bitcnt <= '0;
                            state  <= cfg_q.par_en ? SER_PAR : SER_STOP;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                SER_PAR: begin
                    if (cell_end) begin
                        bitcnt <= '0;
                        state  <= SER_STOP;
                    end
                end
                SER_STOP: begin
                    if (cell_end) begin
                        if (cfg_q.two_stop && bitcnt == 4'd0) bitcnt <= 4'd1;
                        else                                  state  <= SER_IDLE;
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/framer_rx.sv
module framer_rx
    import framer_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic                rxs,
    output logic                push,
    output logic [MAX_BITS-1:0] data,
    output logic                perr,
    output logic                ferr,
    output logic                brk
);
    localparam int CW   = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int HALF = (OSR / 2 > 0) ? OSR / 2 : 1;

    ser_state_e          state;
    frame_cfg_t          cfg_q;
    logic [MAX_BITS-1:0] shreg;
    logic [3:0]          bitcnt;
    logic [CW-1:0]       tcnt;
    logic                par_s;
    logic                any_one;
    logic                mid;
    logic [3:0]          nbits;
    logic [MAX_BITS-1:0] aligned;

    assign nbits   = data_bits(cfg_q.len);
    assign aligned = shreg >> (4'(MAX_BITS) - nbits);
    assign mid     = tick && (tcnt == CW'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SER_IDLE;
            cfg_q   <= '0;
            shreg   <= '0;
            bitcnt  <= '0;
            tcnt    <= '0;
            par_s   <= 1'b0;
            any_one <= 1'b0;
            push    <= 1'b0;
            data    <= '0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            brk     <= 1'b0;
        end else begin
            push <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
            brk  <= 1'b0;
            case (state)
                SER_IDLE: begin
                    if (tick && !rxs) begin
                        cfg_q   <= cfg;
                        shreg   <= '0;
                        any_one <= 1'b0;
                        par_s   <= 1'b0;
                        tcnt    <= '0;
                        state   <= SER_START;
                    end
                end
                SER_START: begin
                    if (tick) begin
                        if (tcnt == CW'(HALF - 1)) begin
                            tcnt   <= '0;
                            bitcnt <= '0;
                            state  <= rxs ? SER_IDLE : SER_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                SER_DATA: begin
                    if (tick) tcnt <= mid ? '0 : tcnt + 1'b1;
                    if (mid) begin
                        shreg   <= {rxs, shreg[MAX_BITS-1:1]};
                        any_one <= any_one | rxs;
                        if (bitcnt == nbits - 4'd1)
                            state <= cfg_q.par_en ? SER_PAR : SER_STOP;
                        else
                            bitcnt <= bitcnt + 4'd1;
                    end
                end
                SER_PAR: begin
                    if (tick) tcnt <= mid ? '0 : tcnt + 1'b1;
                    if (mid) begin
                        par_s   <= rxs;
                        any_one <= any_one | rxs;
                        state   <= SER_STOP;
                    end
                end
                SER_STOP: begin
                    if (tick) tcnt <= mid ? '0 : tcnt + 1'b1;
                    if (mid) begin
                        push  <= 1'b1;
                        data  <= aligned;
                        ferr  <= !rxs;
                        perr  <= cfg_q.par_en && (par_s != par_bit(aligned, cfg_q.par_odd));
                        brk   <= !rxs && !any_one;
                        state <= rxs ? SER_IDLE : SER_HOLD;
                    end
                end
                SER_HOLD: begin
                    if (rxs) state <= SER_IDLE;
                end
                default: state <= SER_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_framer_top.sv
module serial_framer_top
    import framer_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [21:15] ctrl_fmt,
    input  logic         txq_empty,
    input  logic [7:0]   txq_data,
    input  logic         cts_n,
    output logic         txq_pop,
    output logic         txd,
    output logic         tx_busy,
    output logic         tx_idle,
    input  logic         rxd,
    output logic         rxq_push,
    output logic [7:0]   rxq_data,
    output logic         rx_parity_err,
    output logic         rx_frame_err,
    output logic         rx_break
);
    frame_cfg_t cfg;
    logic       rx_line;

    assign cfg     = unpack_cfg(ctrl_fmt);
    assign tx_idle = txq_empty && !tx_busy;

    framer_tx #(.OSR(OSR)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cfg       (cfg),
        .txq_empty (txq_empty),
        .txq_data  (txq_data),
        .cts_n     (cts_n),
        .txq_pop   (txq_pop),
        .txd       (txd),
        .busy      (tx_busy)
    );

    framer_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_line)
    );

    framer_rx #(.OSR(OSR)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cfg  (cfg),
        .rxs  (rx_line),
        .push (rxq_push),
        .data (rxq_data),
        .perr (rx_parity_err),
        .ferr (rx_frame_err),
        .brk  (rx_break)
    );
endmodule

// File: rtl/framer_checks.sv
module framer_checks (
    input logic         clk,
    input logic         rst,
    input logic [21:15] ctrl_fmt,
    input logic         txq_empty,
    input logic         cts_n,
    input logic         txq_pop,
    input logic         txd,
    input logic         tx_busy,
    input logic         rxq_push,
    input logic [7:0]   rxq_data,
    input logic         rx_parity_err,
    input logic         rx_frame_err,
    input logic         rx_break
);
    AST_LINE_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd); // R1

    AST_POP_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        txq_pop |-> (!tx_busy && !txq_empty)); // R6

    AST_BUSY_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
        txq_pop |=> (tx_busy && !txd)); // R6

    AST_CTS_GATES_START: assert property (@(posedge clk) disable iff (rst)
        (txq_pop && !ctrl_fmt[15]) |-> !cts_n); // R7

    AST_BREAK_IS_ZERO_FRAME: assert property (@(posedge clk) disable iff (rst)
        rx_break |-> (rx_frame_err && rxq_data == 8'h00)); // R12

    AST_FLAGS_ONLY_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
        (rx_parity_err || rx_frame_err || rx_break) |-> rxq_push); // R13

    AST_PUSH_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
        rxq_push |=> !rxq_push); // R13
endmodule

bind serial_framer_top framer_checks u_chk (.*);

// File: tb/serial_framer_top_test.sv
module serial_framer_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int CELL       = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic [21:15] ctrl_fmt = 7'b0000001;
    logic         txq_empty = 1'b1;
    logic [7:0]   txq_data = 8'h00;
    logic         cts_n = 1'b1;
    logic         rxd = 1'b1;
    logic         txq_pop, txd, tx_busy, tx_idle;
    logic         rxq_push, rx_parity_err, rx_frame_err, rx_break;
    logic [7:0]   rxq_data;

    int checks = 0;
    int errors = 0;
    int tdiv = 0;
    int pushes = 0;
    logic [7:0] got_data = 8'h00;
    logic got_pe = 1'b0, got_fe = 1'b0, got_brk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    always @(negedge clk) begin
        if (rxq_push) begin
            pushes++;
            got_data = rxq_data;
            got_pe   = rx_parity_err;
            got_fe   = rx_frame_err;
            got_brk  = rx_break;
        end
    end

    serial_framer_top uut (
        .clk(clk), .rst(rst), .tick(tick), .ctrl_fmt(ctrl_fmt),
        .txq_empty(txq_empty), .txq_data(txq_data), .cts_n(cts_n),
        .txq_pop(txq_pop), .txd(txd), .tx_busy(tx_busy), .tx_idle(tx_idle),
        .rxd(rxd), .rxq_push(rxq_push), .rxq_data(rxq_data),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_break(rx_break)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [21:15] fmt(input logic [1:0] len, input bit pen, input bit podd,
                                          input bit two, input bit wire2);
        return {len, pen, podd, 1'b0, two, wire2};
    endfunction

    task automatic wait_cells(input int n);
        repeat (n * CELL) @(negedge clk);
    endtask

    // Load one queue entry and return at the negedge after the consuming edge.
    task automatic load_tx(input logic [7:0] d, input string req);
        int guard = 0;
        txq_data  = d;
        txq_empty = 1'b0;
        @(negedge clk);
        while (!txq_pop && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(txq_pop == 1'b1, req, txq_pop, 1);
        @(negedge clk);
        txq_empty = 1'b1;
    endtask

    task automatic check_tx(input logic [7:0] d, input logic [1:0] len, input bit pen,
                            input bit podd, input bit two, input string req);
        int n = 8 - len;
        logic [7:0] m = d & (8'hFF >> len);
        ctrl_fmt = fmt(len, pen, podd, two, 1'b1);
        load_tx(d, req);
        chk(tx_busy == 1'b1, "R6 busy after pop", tx_busy, 1);
        repeat (31) @(negedge clk);
        chk(txd == 1'b0, "R3 start bit", txd, 0);
        for (int i = 0; i < n; i++) begin
            repeat (CELL) @(negedge clk);
            chk(txd == m[i], $sformatf("%s R2/R3 data bit %0d", req, i), txd, m[i]);
        end
        if (pen) begin
            repeat (CELL) @(negedge clk);
            chk(txd == ((^m) ^ podd), "R4 parity bit", txd, (^m) ^ podd);
        end
        repeat (CELL) @(negedge clk);
        chk(txd == 1'b1, "R5 first stop", txd, 1);
        if (two) begin
            repeat (CELL) @(negedge clk);
            chk(txd == 1'b1 && tx_busy == 1'b1, "R5 second stop busy", {txd, tx_busy}, 3);
        end
        repeat (CELL) @(negedge clk);
        chk(tx_busy == 1'b0 && txd == 1'b1, "R5 done after stops", {txd, tx_busy}, 2);
        chk(tx_idle == 1'b1, "R8 idle when empty and done", tx_idle, 1);
    endtask

    task automatic drive_rx(input logic [7:0] d, input int n, input bit pen, input bit pval,
                            input bit stop_lvl);
        rxd = 1'b0;
        wait_cells(1);
        for (int i = 0; i < n; i++) begin
            rxd = d[i];
            wait_cells(1);
        end
        if (pen) begin
            rxd = pval;
            wait_cells(1);
        end
        rxd = stop_lvl;
        wait_cells(1);
        rxd = 1'b1;
    endtask

    task automatic test_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1 && tx_busy == 1'b0, "R1 line idle after reset", {txd, tx_busy}, 2);
        chk(rxq_push == 1'b0 && txq_pop == 1'b0, "R1 no handshake after reset", {rxq_push, txq_pop}, 0);
        chk(tx_idle == 1'b1, "R8 idle at reset", tx_idle, 1);
    endtask

    task automatic test_tx_formats();
        check_tx(8'hA5, 2'd0, 1'b0, 1'b0, 1'b0, "R3 8N1");
        check_tx(8'hFF, 2'd3, 1'b0, 1'b0, 1'b0, "R2 5-bit");
        check_tx(8'h53, 2'd1, 1'b1, 1'b0, 1'b0, "R4 7E1");
        check_tx(8'h53, 2'd0, 1'b1, 1'b1, 1'b1, "R4 8O2");
        check_tx(8'h2C, 2'd2, 1'b0, 1'b0, 1'b1, "R5 6N2");
    endtask

    task automatic test_busy_flag();
        bit seen_pop = 1'b0;
        ctrl_fmt  = fmt(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        txq_data  = 8'h11;
        txq_empty = 1'b0;
        @(negedge clk);
        chk(tx_idle == 1'b0, "R8 not idle with entry queued", tx_idle, 0);
        @(negedge clk);
        txq_empty = 1'b1;
        repeat (200) begin
            @(negedge clk);
            if (txq_pop) seen_pop = 1'b1;
        end
        chk(tx_busy == 1'b1 && tx_idle == 1'b0, "R8 not idle while shifting", {tx_busy, tx_idle}, 2);
        chk(!seen_pop, "R6 no pop while busy", seen_pop, 0);
        wait_cells(10);
        chk(tx_idle == 1'b1, "R8 idle after frame", tx_idle, 1);
    endtask

    task automatic test_cts();
        bit seen_pop = 1'b0;
        ctrl_fmt  = fmt(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        cts_n     = 1'b1;
        txq_data  = 8'h3C;
        txq_empty = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (txq_pop) seen_pop = 1'b1;
        end
        chk(!seen_pop && txd == 1'b1 && tx_busy == 1'b0, "R7 held by cts_n",
            {seen_pop, txd, tx_busy}, 2);
        cts_n = 1'b0;
        load_tx(8'h3C, "R7 start after cts_n low");
        wait_cells(11);
        chk(tx_busy == 1'b0, "R7 frame finished", tx_busy, 0);
        cts_n = 1'b1;
    endtask

    task automatic expect_rx(input logic [7:0] d, input bit pe, input bit fe, input bit bk,
                             input int pushes0, input string req);
        chk(pushes == pushes0 + 1, {req, " push count"}, pushes - pushes0, 1);
        chk(got_data == d, {req, " data"}, got_data, d);
        chk({got_pe, got_fe, got_brk} == {pe, fe, bk}, {req, " flags"},
            {got_pe, got_fe, got_brk}, {pe, fe, bk});
    endtask

    task automatic test_rx();
        int p0;
        ctrl_fmt = fmt(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        p0 = pushes; drive_rx(8'hC6, 8, 1'b0, 1'b0, 1'b1); wait_cells(1);
        expect_rx(8'hC6, 0, 0, 0, p0, "R13 8N1 receive");

        ctrl_fmt = fmt(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        p0 = pushes; drive_rx(8'hDA, 7, 1'b0, 1'b0, 1'b1); wait_cells(1);
        expect_rx(8'h5A, 0, 0, 0, p0, "R2 7-bit receive upper zero");

        ctrl_fmt = fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        p0 = pushes; drive_rx(8'hF5, 5, 1'b0, 1'b0, 1'b1); wait_cells(1);
        expect_rx(8'h15, 0, 0, 0, p0, "R2 5-bit receive");

        ctrl_fmt = fmt(2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        p0 = pushes; drive_rx(8'h03, 8, 1'b1, 1'b1, 1'b1); wait_cells(1);
        expect_rx(8'h03, 0, 0, 0, p0, "R10 odd parity good");

        ctrl_fmt = fmt(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        p0 = pushes; drive_rx(8'h03, 8, 1'b1, 1'b1, 1'b1); wait_cells(1);
        expect_rx(8'h03, 1, 0, 0, p0, "R10 even parity bad");

        ctrl_fmt = fmt(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        p0 = pushes; drive_rx(8'h55, 8, 1'b0, 1'b0, 1'b0); wait_cells(1);
        expect_rx(8'h55, 0, 1, 0, p0, "R11 framing error");
    endtask

    task automatic test_break();
        int p0 = pushes;
        ctrl_fmt = fmt(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        rxd = 1'b0;
        wait_cells(14);
        expect_rx(8'h00, 0, 1, 1, p0, "R12 break");
        rxd = 1'b1;
        wait_cells(3);
        chk(pushes == p0 + 1, "R12 single byte for break", pushes - p0, 1);
    endtask

    task automatic test_false_start();
        int p0 = pushes;
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        wait_cells(12);
        chk(pushes == p0, "R9 short low pulse rejected", pushes - p0, 0);
        p0 = pushes; drive_rx(8'h81, 8, 1'b0, 1'b0, 1'b1); wait_cells(1);
        expect_rx(8'h81, 0, 0, 0, p0, "R9 receiver rearmed");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_tx_formats();
        test_busy_flag();
        test_cts();
        test_rx();
        test_break();
        test_false_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule